// File: doc/BRIEF.md
# Time and Date Seven-Segment Decoder Bank

This block turns the BCD fields of a 24-hour clock readout (hours, minutes, seconds) and the two digits of the day of the month into segment enables for eight seven-segment digits. Every segment output is active high: a 1 turns on an external transistor that pulls that segment's cathode low on a common-anode display. A separate output lights the decimal point of the day-of-month units digit while leap-year mode is on.

Each digit position gets a decoder sized to its field. The units digits take 4-bit codes, the minutes-tens and seconds-tens digits take 3-bit codes, and the hours-tens and day-tens digits share a 2-bit design. A code outside a decoder's legal range turns off all seven segments, so the display never shows a partial or odd glyph. The 2-bit decoder also accepts 3 because the day-tens digit needs it. The block has no registers, so every output follows its inputs in the same cycle.

Top module: `clk_seg_decode_bank`

## Requirements
- R1: Segment vectors put segment a in bit 0 and segment g in bit 6. On a 4-bit units digit, codes 0 to 9 give these glyphs: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D (segment a lit), 7=0x07 (a,b,c only), 8=0x7F, 9=0x6F (segment d lit).
- R2: On a units digit, codes 10 to 15 give 0x00, which is a blank digit.
- R3: On the minutes-tens and seconds-tens digits (3-bit codes), codes 0 to 5 give the same glyphs that R1 lists.
- R4: On the minutes-tens and seconds-tens digits, codes 6 and 7 give 0x00.
- R5: The hours-tens digit (2-bit code) shows every code from 0 to 3 with the glyphs from R1.
- R6: The day-tens digit uses the same 2-bit decoder. Code 3 shows as 0x4F.
- R7: `dp_day_ones` is 1 exactly when `leap_mode` is 1. The leap input has no effect on any segment vector.
- R8: The block is purely combinational. Each digit's segments depend only on that digit's own input, so an illegal code on one field leaves every other digit's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hr_tens | input | 2 | Hours tens code |
| hr_ones | input | 4 | Hours units code |
| min_tens | input | 3 | Minutes tens code |
| min_ones | input | 4 | Minutes units code |
| sec_tens | input | 3 | Seconds tens code |
| sec_ones | input | 4 | Seconds units code |
| day_tens | input | 2 | Day-of-month tens code |
| day_ones | input | 4 | Day-of-month units code |
| leap_mode | input | 1 | Leap-year mode flag |
| seg_hr_tens | output | 7 | Segments, hours tens (bit0=a .. bit6=g) |
| seg_hr_ones | output | 7 | Segments, hours units |
| seg_min_tens | output | 7 | Segments, minutes tens |
| seg_min_ones | output | 7 | Segments, minutes units |
| seg_sec_tens | output | 7 | Segments, seconds tens |
| seg_sec_ones | output | 7 | Segments, seconds units |
| seg_day_tens | output | 7 | Segments, day tens |
| seg_day_ones | output | 7 | Segments, day units |
| dp_day_ones | output | 1 | Decimal point, day units digit |

## Verification
Three sweeps drive every code of each width. The first drives all four units fields together through 0 to 15, which shows the exact glyph table and the blanking above 9. The second drives the two 3-bit tens fields through 0 to 7, which shows where blanking starts at 6. The third drives both 2-bit fields through 0 to 3, which confirms that 3 is decoded. Walking patterns then put an illegal code on one field at a time while the other fields hold legal values, which catches a digit reading its neighbour's input. A leap toggle with fixed digits shows that the decimal point follows the flag and that no segment vector changes with it.

// File: rtl/seg_glyph_pkg.sv
package seg_glyph_pkg;

    localparam int SEG_W  = 7;
    localparam int CODE_W = 4;

    typedef logic [SEG_W-1:0] seg_t;

    // Highest legal code for a decoder of the given input width.
    function automatic int legal_limit(input int width);
        if (width <= 2)
            return 3;
        else if (width == 3)
            return 5;
        else
            return 9;
    endfunction

    // bit0 = a ... bit6 = g
    function automatic seg_t glyph(input logic [CODE_W-1:0] v);
        seg_t s;
        case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcd_range_gate.sv
module bcd_range_gate #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] code,
    output logic             in_range
);
    import seg_glyph_pkg::*;

    localparam int LIMIT = legal_limit(WIDTH);
    localparam int SPAN  = 1 << WIDTH;

    generate
        if (LIMIT >= SPAN - 1) begin : g_full
            // Every code of this width is legal.
            logic unused_code;
            assign unused_code = ^code;
            assign in_range    = 1'b1;
        end else begin : g_limited
            always_comb begin
                in_range = (int'(code) <= LIMIT);
            end
        end
    endgenerate

endmodule

// File: rtl/bcd_digit_decode.sv
module bcd_digit_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]              code,
    output logic [seg_glyph_pkg::SEG_W-1:0] seg
);
    import seg_glyph_pkg::*;

    logic                in_range;
    logic [CODE_W-1:0]   code_w;
    seg_t                seg_d;

    bcd_range_gate #(.WIDTH(WIDTH)) u_gate (
        .code     (code),
        .in_range (in_range)
    );

    always_comb begin
        code_w = CODE_W'(code);
        seg_d  = in_range ? glyph(code_w) : '0;
    end

    assign seg = seg_d;

    always_comb begin
        // R2 R4
        if (!in_range) begin
            illegal_is_blank_chk: assert (seg == '0);
        end
        // R8
        if (in_range) begin
            legal_not_blank_chk: assert (seg != '0);
        end
        // R1
        if (int'(code) == 1) begin
            one_two_segs_chk: assert ($countones(seg) == 2);
        end
        // R1
        if (int'(code) == 8) begin
            eight_all_segs_chk: assert (seg == 7'h7F);
        end
    end

endmodule

// File: rtl/clk_seg_decode_bank.sv
module clk_seg_decode_bank (
    input  logic [1:0] hr_tens,
    input  logic [3:0] hr_ones,
    input  logic [2:0] min_tens,
    input  logic [3:0] min_ones,
    input  logic [2:0] sec_tens,
    input  logic [3:0] sec_ones,
    input  logic [1:0] day_tens,
    input  logic [3:0] day_ones,
    input  logic       leap_mode,
    output logic [6:0] seg_hr_tens,
    output logic [6:0] seg_hr_ones,
    output logic [6:0] seg_min_tens,
    output logic [6:0] seg_min_ones,
    output logic [6:0] seg_sec_tens,
    output logic [6:0] seg_sec_ones,
    output logic [6:0] seg_day_tens,
    output logic [6:0] seg_day_ones,
    output logic       dp_day_ones
);
    import seg_glyph_pkg::*;

    localparam int N_ONES = 4;
    localparam int N_TENS3 = 2;
    localparam int N_TENS2 = 2;

    logic [3:0] ones_code [N_ONES];
    seg_t       ones_seg  [N_ONES];
    logic [2:0] t3_code   [N_TENS3];
    seg_t       t3_seg    [N_TENS3];
    logic [1:0] t2_code   [N_TENS2];
    seg_t       t2_seg    [N_TENS2];

    assign ones_code[0] = hr_ones;
    assign ones_code[1] = min_ones;
    assign ones_code[2] = sec_ones;
    assign ones_code[3] = day_ones;
    assign t3_code[0]   = min_tens;
    assign t3_code[1]   = sec_tens;
    assign t2_code[0]   = hr_tens;
    assign t2_code[1]   = day_tens;

    generate
        for (genvar i = 0; i < N_ONES; i++) begin : g_ones
            bcd_digit_decode #(.WIDTH(4)) u_dec (
                .code (ones_code[i]),
                .seg  (ones_seg[i])
            );
        end
        for (genvar i = 0; i < N_TENS3; i++) begin : g_tens3
            bcd_digit_decode #(.WIDTH(3)) u_dec (
                .code (t3_code[i]),
                .seg  (t3_seg[i])
            );
        end
        for (genvar i = 0; i < N_TENS2; i++) begin : g_tens2
            bcd_digit_decode #(.WIDTH(2)) u_dec (
                .code (t2_code[i]),
                .seg  (t2_seg[i])
            );
        end
    endgenerate

    assign seg_hr_ones  = ones_seg[0];
    assign seg_min_ones = ones_seg[1];
    assign seg_sec_ones = ones_seg[2];
    assign seg_day_ones = ones_seg[3];
    assign seg_min_tens = t3_seg[0];
    assign seg_sec_tens = t3_seg[1];
    assign seg_hr_tens  = t2_seg[0];
    assign seg_day_tens = t2_seg[1];
    assign dp_day_ones  = leap_mode;

    always_comb begin
        // R6
        if (day_tens == 2'd3) begin
            day_tens_three_chk: assert (seg_day_tens == 7'h4F);
        end
    end

endmodule

// File: tb/clk_seg_decode_bank_test.sv
module clk_seg_decode_bank_test;

    typedef struct {
        logic [56:0] outs;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [1:0] hr_tens, day_tens;
    logic [2:0] min_tens, sec_tens;
    logic [3:0] hr_ones, min_ones, sec_ones, day_ones;
    logic       leap_mode;
    logic [6:0] s_ht, s_ho, s_mt, s_mo, s_st, s_so, s_dt, s_do;
    logic       dp;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];
    bit done = 1'b0;

    clk_seg_decode_bank uut (
        .hr_tens(hr_tens), .hr_ones(hr_ones),
        .min_tens(min_tens), .min_ones(min_ones),
        .sec_tens(sec_tens), .sec_ones(sec_ones),
        .day_tens(day_tens), .day_ones(day_ones),
        .leap_mode(leap_mode),
        .seg_hr_tens(s_ht), .seg_hr_ones(s_ho),
        .seg_min_tens(s_mt), .seg_min_ones(s_mo),
        .seg_sec_tens(s_st), .seg_sec_ones(s_so),
        .seg_day_tens(s_dt), .seg_day_ones(s_do),
        .dp_day_ones(dp)
    );

    function automatic logic [6:0] ref_seg(input int v, input int maxv);
        if (v > maxv) return 7'h00;
        case (v)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic drive(input int ht, input int ho, input int mt, input int mo,
                         input int st, input int so, input int dt, input int dn,
                         input bit lp, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        hr_tens = 2'(ht); hr_ones = 4'(ho);
        min_tens = 3'(mt); min_ones = 4'(mo);
        sec_tens = 3'(st); sec_ones = 4'(so);
        day_tens = 2'(dt); day_ones = 4'(dn);
        leap_mode = lp;
        e.outs = {ref_seg(ht, 3), ref_seg(ho, 9), ref_seg(mt, 5), ref_seg(mo, 9),
                  ref_seg(st, 5), ref_seg(so, 9), ref_seg(dt, 3), ref_seg(dn, 9), lp};
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                logic [56:0] got;
                e   = sb.pop_front();
                got = {s_ht, s_ho, s_mt, s_mo, s_st, s_so, s_dt, s_do, dp};
                checks++;
                if (got !== e.outs) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, got, e.outs);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        hr_tens = 0; hr_ones = 0; min_tens = 0; min_ones = 0;
        sec_tens = 0; sec_ones = 0; day_tens = 0; day_ones = 0; leap_mode = 0;
        // idle state: all zero fields
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle zeros");
        // R1 R2: units sweep
        for (int v = 0; v < 16; v++)
            drive(1, v, 2, v, 3, v, 1, v, 0, (v < 10) ? "R1 units glyph" : "R2 units blank");
        // R3 R4: 3-bit tens sweep
        for (int v = 0; v < 8; v++)
            drive(0, 5, v, 7, v, 2, 2, 4, 0, (v < 6) ? "R3 tens glyph" : "R4 tens blank");
        // R5 R6: 2-bit sweep
        for (int v = 0; v < 4; v++)
            drive(v, 0, 0, 0, 0, 0, v, 1, 0, (v == 3) ? "R6 two-bit code 3" : "R5 two-bit glyph");
        // R7: leap toggles with fixed digits
        drive(2, 3, 5, 9, 5, 9, 2, 9, 1, "R7 leap on");
        drive(2, 3, 5, 9, 5, 9, 2, 9, 0, "R7 leap off");
        drive(0, 0, 0, 0, 0, 0, 3, 1, 1, "R7 leap on day 31");
        // R8: one illegal field at a time
        drive(1, 12, 4, 8, 3, 6, 2, 5, 0, "R8 hr ones illegal");
        drive(1, 7, 6, 8, 3, 6, 2, 5, 0, "R8 min tens illegal");
        drive(1, 7, 4, 15, 3, 6, 2, 5, 1, "R8 min ones illegal");
        drive(1, 7, 4, 8, 7, 6, 2, 5, 0, "R8 sec tens illegal");
        drive(1, 7, 4, 8, 3, 10, 2, 5, 1, "R8 sec ones illegal");
        drive(1, 7, 4, 8, 3, 6, 2, 11, 0, "R8 day ones illegal");
        drive(2, 3, 5, 9, 5, 9, 3, 0, 0, "R8 max time 23:59:59");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule